// File: doc/BRIEF.md
# Two-Wire Register Slave Interface

This block is a slave on a two-wire serial bus. It gives a bus host read and write access to a bank of 16-bit control registers, each selected by an 8-bit register pointer. The bank sits outside the block behind a simple parallel port. That port carries an address, a write strobe with write data, and a combinational read-data return. The two bus lines are sampled into the system clock domain through synchronizers. All bus timing is then derived from edges that the block detects on the synchronized copies. The serial data line is split into an input, an output enable and an output value, so the pad or the bench forms the wired-AND bus.

A write transaction carries the device address with the direction bit clear, then a pointer byte, then data bytes. Every two data bytes form one register word, high byte first. A read first sets the pointer with a short write. A repeated start then follows with the direction bit set. The slave returns words high byte first until the host answers a byte with no-acknowledge. The pointer advances by one per 16-bit word in both directions.

The control state machine has ten states. TW_IDLE waits for a start. TW_DEV shifts in the device byte. A match moves to TW_DEV_ACK, and a mismatch moves to TW_SKIP, which stays deaf until the next start. From TW_DEV_ACK, a set direction bit leads to TW_RD. A clear direction bit leads to TW_PTR, then TW_PTR_ACK. Writes then alternate between TW_WR and TW_WR_ACK. Reads alternate between TW_RD and TW_RD_ACK. A no-acknowledge in TW_RD_ACK goes to TW_SKIP. A start from any state enters TW_DEV, and a stop from any state enters TW_IDLE.

Top module: `twr_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start, and it moves the slave to device-address reception from any state. A rising data line while the clock line is high is a stop; it returns the slave to idle with the data line released.
- R2: The slave acknowledges a device byte whose upper seven bits equal the DEV_ADDR parameter (default 1011100), by driving the data line low for the ninth clock. Bit 0 of that byte selects the direction: 0 for write (0xB8) and 1 for read (0xB9).
- R3: On a device-address mismatch the slave gives no acknowledge. It then neither acknowledges nor writes anything until the next start.
- R4: In a write, the slave takes the first byte after the device byte as the register pointer. It acknowledges the pointer byte and every data byte.
- R5: Data bytes travel MSB first, and the high byte of a word precedes the low byte. Once both bytes of a word are received, the write strobe reg_we pulses for exactly one cycle, with reg_wdata = {high, low} and reg_addr = pointer.
- R6: The pointer advances by one after each 16-bit word (after each write strobe, or once a read word is taken for sending). It wraps from 0xFF to 0x00.
- R7: After a repeated start with the read address, the slave returns the word at the pointer, MSB first and high byte first, and keeps returning consecutive words while the host acknowledges.
- R8: A no-acknowledge from the host ends the read, and the slave releases the data line for the rest of the transaction.
- R9: A word that has only one byte received when a stop or start arrives is discarded, and no strobe is produced for it.
- R10: A repeated start ends a write burst, and the following device byte begins a new transaction. The pointer set in the earlier write is kept.
- R11: Out of reset the slave releases the data line, keeps reg_we low and holds the pointer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line from the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Drive enable for the data line |
| sda_o | output | 1 | Value driven on the data line while enabled |
| reg_addr | output | AW | Register pointer presented to the register bank |
| reg_wdata | output | DW | Assembled register word for a write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | DW | Word read from the bank at reg_addr |

## Verification
The bench builds the block with its defaults: DEV_ADDR of 1011100, an 8-bit pointer, 16-bit words and two synchronizer stages. With two bytes per word, the byte-order rules, the partial-word discard and the per-word pointer step can all be observed. The 256-entry pointer space is small enough that the bench can model the entire register bank in behavioural code. The bus clock phases last five system clocks, which leaves room for the three-cycle synchronizer and edge-detect latency before each bus edge.

// File: rtl/twr_pkg.sv
package twr_pkg;
    typedef enum logic [3:0] {
        TW_IDLE,
        TW_DEV,
        TW_DEV_ACK,
        TW_PTR,
        TW_PTR_ACK,
        TW_WR,
        TW_WR_ACK,
        TW_RD,
        TW_RD_ACK,
        TW_SKIP
    } tw_state_t;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d_i};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= d_i;
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/twr_busdet.sv
module twr_busdet (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twr_slave.sv
module twr_slave
    import twr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1011100,
    parameter int         AW          = 8,
    parameter int         DW          = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic          sda_o,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    input  logic [DW-1:0] reg_rdata
);
    localparam int NB  = DW / 8;
    localparam int BIW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [BIW-1:0] LAST_BYTE = BIW'(NB - 1);

    logic [1:0] sync_q;
    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    twr_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(sync_q)
    );
    assign scl_s = sync_q[1];
    assign sda_s = sync_q[0];

    twr_busdet u_det (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    tw_state_t state, nxt;
    logic [3:0]     bit_cnt;
    logic [7:0]     shreg;
    logic [7:0]     txreg;
    logic [BIW-1:0] byte_idx;
    logic [AW-1:0]  ptr;
    logic [DW-1:0]  wacc;
    logic [DW-1:0]  word_q;
    logic [DW-1:0]  wdata_q;
    logic           we_q;
    logic           rw_q;
    logic           nack_q;
    logic           byte_done;

    assign byte_done = scl_fall && (bit_cnt == 4'd8);

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = TW_DEV;
        end else if (stop_det) begin
            nxt = TW_IDLE;
        end else begin
            unique case (state)
                TW_IDLE, TW_SKIP: nxt = state;
                TW_DEV:     if (byte_done) nxt = (shreg[7:1] == DEV_ADDR) ? TW_DEV_ACK : TW_SKIP;
                TW_DEV_ACK: if (scl_fall)  nxt = rw_q ? TW_RD : TW_PTR;
                TW_PTR:     if (byte_done) nxt = TW_PTR_ACK;
                TW_PTR_ACK: if (scl_fall)  nxt = TW_WR;
                TW_WR:      if (byte_done) nxt = TW_WR_ACK;
                TW_WR_ACK:  if (scl_fall)  nxt = TW_WR;
                TW_RD:      if (scl_fall && bit_cnt == 4'd7) nxt = TW_RD_ACK;
                TW_RD_ACK:  if (scl_fall)  nxt = nack_q ? TW_SKIP : TW_RD;
                default:    nxt = TW_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TW_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            txreg    <= '0;
            byte_idx <= '0;
            ptr      <= '0;
            wacc     <= '0;
            word_q   <= '0;
            wdata_q  <= '0;
            we_q     <= 1'b0;
            rw_q     <= 1'b0;
            nack_q   <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (we_q) ptr <= ptr + AW'(1);
            if (start_det || stop_det) begin
                bit_cnt  <= '0;
                byte_idx <= '0;
            end else begin
                unique case (state)
                    TW_DEV, TW_PTR, TW_WR: begin
                        if (scl_rise && bit_cnt != 4'd8) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                        if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == TW_DEV) rw_q <= shreg[0];
                            if (state == TW_PTR) begin
                                ptr      <= shreg;
                                byte_idx <= '0;
                            end
                            if (state == TW_WR) begin
                                if (byte_idx == LAST_BYTE) begin
                                    wdata_q  <= {wacc[DW-9:0], shreg};
                                    we_q     <= 1'b1;
                                    byte_idx <= '0;
                                end else begin
                                    wacc     <= {wacc[DW-9:0], shreg};
                                    byte_idx <= byte_idx + BIW'(1);
                                end
                            end
                        end
                    end
                    TW_DEV_ACK, TW_RD_ACK: begin
                        if (scl_rise) nack_q <= sda_s;
                        if (scl_fall && (state == TW_DEV_ACK ? rw_q : !nack_q)) begin
                            bit_cnt <= '0;
                            if (state == TW_DEV_ACK || byte_idx == '0) begin
                                txreg    <= reg_rdata[DW-1 -: 8];
                                word_q   <= reg_rdata << 8;
                                ptr      <= ptr + AW'(1);
                                byte_idx <= BIW'(1);
                            end else begin
                                txreg    <= word_q[DW-1 -: 8];
                                word_q   <= word_q << 8;
                                byte_idx <= (byte_idx == LAST_BYTE) ? '0 : byte_idx + BIW'(1);
                            end
                        end
                    end
                    TW_RD: begin
                        if (scl_fall) begin
                            txreg   <= {txreg[6:0], 1'b0};
                            bit_cnt <= (bit_cnt == 4'd7) ? 4'd0 : bit_cnt + 4'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        sda_o  = 1'b0;
        unique case (state)
            TW_DEV_ACK, TW_PTR_ACK, TW_WR_ACK: sda_oe = 1'b1;
            TW_RD: begin
                sda_oe = 1'b1;
                sda_o  = txreg[7];
            end
            default: ;
        endcase
    end

    assign reg_addr  = ptr;
    assign reg_we    = we_q;
    assign reg_wdata = wdata_q;

    assert_we_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == $past(reg_addr) + AW'(1)));
    assert_start_dev_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == TW_DEV));
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
    assert_nack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TW_RD_ACK && scl_fall && nack_q) |=> !sda_oe);
    assert_skip_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TW_SKIP && !start_det && !stop_det) |=> (state == TW_SKIP));
endmodule

// File: tb/twr_slave_tb.sv
module twr_slave_tb;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe, sda_o, reg_we;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic sda_bus;

    int checks = 0;
    int failures = 0;

    logic [15:0] mem [256];
    logic [15:0] mdl [256];
    logic [7:0]  exp_a [$];
    logic [15:0] exp_d [$];

    always #10 clk = ~clk;

    assign sda_bus   = m_sda & (sda_oe ? sda_o : 1'b1);
    assign reg_rdata = mem[reg_addr];

    twr_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .sda_o(sda_o), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = '0;
            mdl[i] = '0;
        end
    end

    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // reference comparison of the register port on every clock
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_a.size() == 0) begin
                check(1'b0, "R5/R9 unexpected strobe", reg_addr, 0);
            end else begin
                logic [7:0]  ea;
                logic [15:0] ed;
                ea = exp_a.pop_front();
                ed = exp_d.pop_front();
                check(reg_addr == ea, "R6 strobe address", reg_addr, ea);
                check(reg_wdata == ed, "R5 strobe data", reg_wdata, ed);
            end
        end
    end

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_word(input logic [7:0] a, input logic [15:0] d);
        exp_a.push_back(a);
        exp_d.push_back(d);
        mdl[a] = d;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; clks(Q);
        scl = 1'b1;   clks(Q);
        m_sda = 1'b0; clks(Q);
        scl = 1'b0;   clks(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; clks(Q);
        scl = 1'b1;   clks(Q);
        m_sda = 1'b1; clks(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic got;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; clks(Q);
            scl = 1'b1;   clks(2 * Q);
            scl = 1'b0;   clks(Q);
        end
        m_sda = 1'b1; clks(Q);
        scl = 1'b1;   clks(Q);
        got = sda_bus; clks(Q);
        scl = 1'b0;   clks(Q);
        check(got == !exp_ack, req, got, !exp_ack);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit give_ack, input string req);
        logic [7:0] b;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clks(Q);
            scl = 1'b1; clks(Q);
            b[i] = sda_bus; clks(Q);
            scl = 1'b0;
        end
        clks(1);
        m_sda = give_ack ? 1'b0 : 1'b1; clks(Q);
        scl = 1'b1; clks(2 * Q);
        scl = 1'b0; clks(2);
        m_sda = 1'b1;
        check(b == exp, req, b, exp);
    endtask

    task automatic read_words(input logic [7:0] a, input int n, input string req);
        bus_start();
        send_byte(8'hB8, 1'b1, "R2 write address ack");
        send_byte(a, 1'b1, "R4 pointer ack");
        bus_start();
        send_byte(8'hB9, 1'b1, "R2 read address ack");
        for (int w = 0; w < n; w++) begin
            logic [15:0] d;
            d = mdl[8'(a + w)];
            recv_byte(d[15:8], 1'b1, req);
            recv_byte(d[7:0], w != n - 1, req);
        end
        clks(Q);
        check(sda_oe == 1'b0, "R8 released after no-ack", sda_oe, 0);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clks(4);
        rst_n = 1'b1;
        clks(2);
        // R11 reset state
        check(sda_oe == 1'b0, "R11 data line released", sda_oe, 0);
        check(reg_we == 1'b0, "R11 no strobe", reg_we, 0);
        check(reg_addr == 8'h00, "R11 pointer zero", reg_addr, 0);

        // R4 R5 R6 two-word write burst
        expect_word(8'h10, 16'h1234);
        expect_word(8'h11, 16'hABCD);
        bus_start();
        send_byte(8'hB8, 1'b1, "R2 write address ack");
        send_byte(8'h10, 1'b1, "R4 pointer ack");
        send_byte(8'h12, 1'b1, "R4 data ack");
        send_byte(8'h34, 1'b1, "R4 data ack");
        send_byte(8'hAB, 1'b1, "R4 data ack");
        send_byte(8'hCD, 1'b1, "R4 data ack");
        bus_stop();
        check(sda_oe == 1'b0, "R1 released after stop", sda_oe, 0);

        // R9 partial word discarded at stop
        expect_word(8'h20, 16'h5555);
        bus_start();
        send_byte(8'hB8, 1'b1, "R2 write address ack");
        send_byte(8'h20, 1'b1, "R4 pointer ack");
        send_byte(8'h55, 1'b1, "R4 data ack");
        send_byte(8'h55, 1'b1, "R4 data ack");
        send_byte(8'h66, 1'b1, "R9 lone byte ack");
        bus_stop();

        // R3 mismatched device address, following bytes ignored
        bus_start();
        send_byte(8'hA0, 1'b0, "R3 no ack on mismatch");
        send_byte(8'hB8, 1'b0, "R3 ignored byte");
        send_byte(8'h30, 1'b0, "R3 ignored byte");
        bus_stop();

        // R7 R6 combined-format read of two words
        read_words(8'h10, 2, "R7 read data");
        // R9 the discarded byte left 0x21 untouched
        read_words(8'h20, 2, "R9 read after partial");

        // R10 write burst ended by repeated start
        expect_word(8'h40, 16'h0102);
        bus_start();
        send_byte(8'hB8, 1'b1, "R2 write address ack");
        send_byte(8'h40, 1'b1, "R4 pointer ack");
        send_byte(8'h01, 1'b1, "R4 data ack");
        send_byte(8'h02, 1'b1, "R4 data ack");
        send_byte(8'h09, 1'b1, "R10 lone byte ack");
        bus_start();
        send_byte(8'hB9, 1'b1, "R10 read after repeated start");
        recv_byte(8'h00, 1'b1, "R10 pointer kept at 0x41");
        recv_byte(8'h00, 1'b0, "R10 pointer kept at 0x41");
        bus_stop();

        // R6 pointer wrap from 0xFF to 0x00
        expect_word(8'hFF, 16'hBEEF);
        expect_word(8'h00, 16'hC0DE);
        bus_start();
        send_byte(8'hB8, 1'b1, "R2 write address ack");
        send_byte(8'hFF, 1'b1, "R4 pointer ack");
        send_byte(8'hBE, 1'b1, "R4 data ack");
        send_byte(8'hEF, 1'b1, "R4 data ack");
        send_byte(8'hC0, 1'b1, "R4 data ack");
        send_byte(8'hDE, 1'b1, "R4 data ack");
        bus_stop();
        read_words(8'hFF, 2, "R6 wrap read");
        read_words(8'h40, 1, "R10 word written before repeated start");

        clks(10);
        check(exp_a.size() == 0, "R5 all expected strobes seen", exp_a.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule